// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Generator

This block drives the processor reset line of a chip from two sources. The first is supply monitoring. Two already-synchronized flags report the supply state: a trip-comparator flag that is high while the supply sits above the reset threshold, and a validity flag that is high once the supply is high enough for the monitor's output to mean anything. The reset is held while either flag is low. It is let go only after both flags have stayed high, without a break, for a programmable number of clock ticks. This stands in for the nominal 200 ms power-up delay.

The second source is a watchdog that watches the serial-bus chip-select line. A two-flop synchroniser feeds an edge detector, and each falling edge of chip-select restarts the watchdog count. When the count reaches the period chosen by a 2-bit select, the block raises the reset. It does this whether chip-select has been idle high or stuck low. That reset then runs through the same release delay as a supply reset. One select code turns the watchdog off. A parameter sets the output polarity.

Top module: `supv_reset_gen`

## Requirements
- R1: While `rst_n` is low the output is asserted. After `rst_n` rises, the output stays asserted until the release delay of R3 has elapsed.
- R2: On the clock edge after either `supply_ok_i` or `supply_valid_i` is sampled low, the output is asserted. It stays asserted for as long as either flag stays low.
- R3: The output deasserts on the RELEASE_TICKS-th consecutive clock edge at which both supply flags are sampled high.
- R4: If either supply flag is low for even one edge during the release countdown, the countdown starts again from zero.
- R5: With the output deasserted and no chip-select falling edge, the watchdog asserts the output on the L-th clock edge after deassertion. L is WD_TICKS_0 for select code 00, WD_TICKS_1 for 01 and WD_TICKS_2 for 10.
- R6: The watchdog times out the same way whether `cs_n_i` is held high or held low.
- R7: A falling edge on `cs_n_i` that is set up before clock edge e clears the watchdog count at edge e+2. With no further edge, the output then asserts at edge e+2+L.
- R8: Select code 11 disables the watchdog, so that no reset comes from it however long chip-select stays idle.
- R9: A watchdog reset lasts RELEASE_TICKS edges, just like a supply reset. The watchdog then counts a full period again from the deassertion.
- R10: With ACTIVE_HIGH=1 the output is high when asserted. With ACTIVE_HIGH=0 it is the exact complement, with identical timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| supply_ok_i | input | 1 | Synchronized trip comparator: 1 = supply above threshold |
| supply_valid_i | input | 1 | Synchronized supply-valid flag: 1 = monitor output meaningful |
| cs_n_i | input | 1 | Asynchronous serial-bus chip-select, active low |
| wd_sel_i | input | 2 | Watchdog period select: 00, 01, 10 = periods 0, 1, 2; 11 = off |
| cpu_rst_o | output | 1 | Processor reset, polarity set by ACTIVE_HIGH |

## Verification
The bench builds two copies of the block, one per polarity, with RELEASE_TICKS=8 and watchdog periods of 10, 20 and 40 ticks. With these short windows every edge-exact boundary can be reached in a few hundred cycles. The bench sweeps every position of a one-cycle supply dip across the whole release countdown, and every enabled period select with chip-select held high and held low. It also checks the two-cycle synchroniser latency of a chip-select kick, and the off code over several times the longest period.

// File: rtl/supv_pkg.sv
package supv_pkg;
  typedef enum logic [1:0] {
    WD_SHORT = 2'b00,
    WD_MID   = 2'b01,
    WD_LONG  = 2'b10,
    WD_OFF   = 2'b11
  } wd_sel_e;
endpackage

// File: rtl/supv_cs_edge.sv
module supv_cs_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_i,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;
  logic              prev_d;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        assign sync_d[g] = cs_n_i;
      end else begin : g_rest
        assign sync_d[g] = sync_q[g-1];
      end
    end
  endgenerate

  assign prev_d = sync_q[STAGES-1];
  assign fall_o = prev_q & ~sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  // R7: a detected falling edge is a single-cycle pulse
  assert_fall_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/supv_hold_timer.sv
module supv_hold_timer #(
  parameter int unsigned RELEASE_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic good_i,
  input  logic wd_fire_i,
  output logic active_o
);
  localparam int unsigned RCW = (RELEASE_TICKS > 1) ? $clog2(RELEASE_TICKS) : 1;
  localparam logic [RCW-1:0] LAST = RCW'(RELEASE_TICKS - 1);

  logic           active_q, active_d;
  logic [RCW-1:0] cnt_q, cnt_d;
  logic           cnt_en;

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    cnt_en   = 1'b1;
    if (!good_i) begin
      active_d = 1'b1;
      cnt_d    = '0;
    end else if (active_q) begin
      if (cnt_q == LAST) begin
        active_d = 1'b0;
        cnt_d    = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (wd_fire_i) begin
      active_d = 1'b1;
      cnt_d    = '0;
    end else begin
      cnt_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else begin
      active_q <= active_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign active_o = active_q;

  // Checker: run length of consecutive good samples, saturating
  logic [RCW:0] good_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) good_run_q <= '0;
    else if (!good_i) good_run_q <= '0;
    else if (good_run_q < (RCW+1)'(RELEASE_TICKS)) good_run_q <= good_run_q + 1'b1;
  end

  assert_release_after_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_q) |-> good_run_q >= (RCW+1)'(RELEASE_TICKS));

  assert_dip_asserts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(good_i) |-> active_q);
endmodule

// File: rtl/supv_watchdog.sv
module supv_watchdog
  import supv_pkg::*;
#(
  parameter int unsigned WD_TICKS_0 = 2,
  parameter int unsigned WD_TICKS_1 = 2,
  parameter int unsigned WD_TICKS_2 = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hold_i,
  input  logic       kick_i,
  input  logic [1:0] sel_i,
  output logic       fire_o
);
  localparam int unsigned MAX01 = (WD_TICKS_0 > WD_TICKS_1) ? WD_TICKS_0 : WD_TICKS_1;
  localparam int unsigned MAXT  = (MAX01 > WD_TICKS_2) ? MAX01 : WD_TICKS_2;
  localparam int unsigned CW    = $clog2(MAXT + 1);
  localparam logic [CW-1:0] LIM0 = CW'(WD_TICKS_0 - 1);
  localparam logic [CW-1:0] LIM1 = CW'(WD_TICKS_1 - 1);
  localparam logic [CW-1:0] LIM2 = CW'(WD_TICKS_2 - 1);

  logic [CW-1:0] cnt_q, cnt_d, lim;
  logic          en;

  always_comb begin
    case (sel_i)
      WD_SHORT: lim = LIM0;
      WD_MID:   lim = LIM1;
      default:  lim = LIM2;
    endcase
  end

  assign en     = (sel_i != WD_OFF);
  assign fire_o = en && !hold_i && !kick_i && (cnt_q >= lim);

  always_comb begin
    if (hold_i || kick_i || !en || fire_o) cnt_d = '0;
    else                                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R5: count never runs beyond the longest period
  assert_cnt_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(MAXT));

  // R7: a kick leaves the count at zero
  assert_kick_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    kick_i |=> cnt_q == '0);
endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen
  import supv_pkg::*;
#(
  parameter int unsigned RELEASE_TICKS = 25_000_000,
  parameter int unsigned WD_TICKS_0    = 18_000_000,
  parameter int unsigned WD_TICKS_1    = 75_000_000,
  parameter int unsigned WD_TICKS_2    = 175_000_000,
  parameter int unsigned SYNC_STAGES   = 2,
  parameter bit          ACTIVE_HIGH   = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok_i,
  input  logic       supply_valid_i,
  input  logic       cs_n_i,
  input  logic [1:0] wd_sel_i,
  output logic       cpu_rst_o
);
  logic good;
  logic cs_fall;
  logic wd_fire;
  logic rst_active;

  assign good = supply_ok_i & supply_valid_i;

  supv_cs_edge #(.STAGES(SYNC_STAGES)) u_cs_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n_i (cs_n_i),
    .fall_o (cs_fall)
  );

  supv_watchdog #(
    .WD_TICKS_0 (WD_TICKS_0),
    .WD_TICKS_1 (WD_TICKS_1),
    .WD_TICKS_2 (WD_TICKS_2)
  ) u_watchdog (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold_i (rst_active),
    .kick_i (cs_fall),
    .sel_i  (wd_sel_i),
    .fire_o (wd_fire)
  );

  supv_hold_timer #(.RELEASE_TICKS(RELEASE_TICKS)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .good_i    (good),
    .wd_fire_i (wd_fire),
    .active_o  (rst_active)
  );

  generate
    if (ACTIVE_HIGH) begin : g_pol_high
      assign cpu_rst_o = rst_active;
    end else begin : g_pol_low
      assign cpu_rst_o = ~rst_active;
    end
  endgenerate

  // R9: a watchdog expiry asserts reset on the next edge
  assert_fire_asserts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wd_fire |=> rst_active);

  // R8: with good supply, a new reset needs an enabled watchdog
  assert_off_no_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_active) && $past(good)) |-> ($past(wd_sel_i) != WD_OFF));
endmodule

// File: tb/supv_reset_gen_tb.sv
module supv_reset_gen_tb_top;
  localparam int unsigned REL = 8;
  localparam int unsigned W0  = 10;
  localparam int unsigned W1  = 20;
  localparam int unsigned W2  = 40;

  logic clk = 1'b0;
  logic rst_n;
  logic supply_ok, supply_valid, cs_n;
  logic [1:0] wd_sel;
  logic out_hi, out_lo;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  supv_reset_gen #(.RELEASE_TICKS(REL), .WD_TICKS_0(W0), .WD_TICKS_1(W1),
                   .WD_TICKS_2(W2), .ACTIVE_HIGH(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .supply_ok_i(supply_ok), .supply_valid_i(supply_valid),
    .cs_n_i(cs_n), .wd_sel_i(wd_sel), .cpu_rst_o(out_hi));

  supv_reset_gen #(.RELEASE_TICKS(REL), .WD_TICKS_0(W0), .WD_TICKS_1(W1),
                   .WD_TICKS_2(W2), .ACTIVE_HIGH(1'b0)) dut_lo_i (
    .clk(clk), .rst_n(rst_n), .supply_ok_i(supply_ok), .supply_valid_i(supply_valid),
    .cs_n_i(cs_n), .wd_sel_i(wd_sel), .cpu_rst_o(out_lo));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // exp = 1 means reset asserted; both polarities checked (R10)
  task automatic chk(input string req, input logic exp);
    checks++;
    if (out_hi !== exp || out_lo !== ~exp) begin
      fails++;
      $display("FAIL %s (R10 pair): hi=%b lo=%b expected hi=%b lo=%b at %0t",
               req, out_hi, out_lo, exp, ~exp, $time);
    end
  endtask

  function automatic int per(input int s);
    return (s == 0) ? W0 : (s == 1) ? W1 : W2;
  endfunction

  // Force a reset by a short supply drop, then release; returns at deassertion
  task automatic restart(input logic cs_level);
    supply_ok = 1'b0;
    cs_n = cs_level;
    tick(4);
    supply_ok = 1'b1;
    tick(REL);
  endtask

  initial begin
    rst_n = 1'b0; supply_ok = 1'b1; supply_valid = 1'b1; cs_n = 1'b1; wd_sel = 2'b00;
    tick(3);
    chk("R1 in reset", 1'b1);
    rst_n = 1'b1;
    tick(REL - 1);
    chk("R1 held after rst_n", 1'b1);
    tick(1);
    chk("R3 release after REL", 1'b0);

    // R2: each flag on its own
    supply_valid = 1'b0;
    tick(1);
    chk("R2 valid low", 1'b1);
    tick(5);
    chk("R2 stays while low", 1'b1);
    supply_valid = 1'b1;
    tick(REL - 1);
    chk("R3 not yet", 1'b1);
    tick(1);
    chk("R3 released", 1'b0);
    supply_ok = 1'b0;
    tick(1);
    chk("R2 ok low", 1'b1);
    supply_ok = 1'b1;
    tick(REL);
    chk("R3 released again", 1'b0);

    // R4: sweep a one-cycle dip through every countdown position
    for (int d = 1; d < int'(REL); d++) begin
      supply_ok = 1'b0;
      tick(2);
      supply_ok = 1'b1;
      tick(d);
      supply_ok = 1'b0;
      tick(1);
      chk("R4 during dip", 1'b1);
      supply_ok = 1'b1;
      tick(REL - 1);
      chk("R4 restarted countdown", 1'b1);
      tick(1);
      chk("R4 release after restart", 1'b0);
    end

    // R5: every enabled period, chip-select idle high
    for (int s = 0; s < 3; s++) begin
      wd_sel = 2'(s);
      restart(1'b1);
      tick(per(s) - 1);
      chk("R5 before period", 1'b0);
      tick(1);
      chk("R5 timeout", 1'b1);
    end

    // R6: chip-select held low
    for (int s = 0; s < 3; s++) begin
      wd_sel = 2'(s);
      restart(1'b0);
      tick(per(s) - 1);
      chk("R6 low before period", 1'b0);
      tick(1);
      chk("R6 low timeout", 1'b1);
    end

    // R7: kick timing through the synchroniser
    for (int s = 0; s < 3; s++) begin
      wd_sel = 2'(s);
      restart(1'b1);
      tick(5);
      cs_n = 1'b0;
      tick(2 + per(s));
      chk("R7 kicked, not yet", 1'b0);
      tick(1);
      chk("R7 timeout after kick", 1'b1);
    end

    // R7: regular kicking keeps reset off
    wd_sel = 2'b00;
    restart(1'b1);
    for (int k = 0; k < 20; k++) begin
      cs_n = 1'b0; tick(3);
      cs_n = 1'b1; tick(3);
    end
    chk("R7 periodic kicks", 1'b0);

    // R9: watchdog reset duration and restart
    cs_n = 1'b1;
    tick(W0 + 3);
    // reset asserted somewhere above; resync to a clean start
    restart(1'b1);
    tick(W0);
    chk("R9 fired", 1'b1);
    tick(REL - 1);
    chk("R9 still held", 1'b1);
    tick(1);
    chk("R9 released", 1'b0);
    tick(W0 - 1);
    chk("R9 recount not yet", 1'b0);
    tick(1);
    chk("R9 second fire", 1'b1);

    // R8: disabled watchdog
    wd_sel = 2'b11;
    restart(1'b1);
    tick(4 * W2);
    chk("R8 off, cs high", 1'b0);
    cs_n = 1'b0;
    tick(4 * W2);
    chk("R8 off, cs low", 1'b0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired: actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule